// File: doc/BRIEF.md
# Latch/Register Bus Driver Slice

This block drives a multi-bit output bus from a per-bit storage element that works in one of two ways. A single latch-enable input picks the way. With latch-enable low, the element is transparent: the output follows the input bus with no clock delay, and storage keeps a copy of what passed through. With latch-enable high, the element acts as a register: it captures the input bus when the bus clock rises and holds that value at all other times. An active-low output enable drives the bus or releases it to high impedance. Storage keeps working while the bus is released, so a value can be loaded behind a tri-stated bus and presented later.

The block runs on a system clock with a synchronous active-low reset. The bus clock, latch-enable and data inputs are assumed to come from the same clock domain as the system clock. The bus clock is a level that the block samples, and it detects the bus clock's rising edge by comparing it with its level at the previous system edge. The transparent path from input to output is combinational.

Top module: `bus_latch_driver`

## Requirements
- R1: The bus width is a parameter (default 20), and every bit behaves identically and independently of the other bits.
- R2: With latch-enable low and output enable low, the output equals the input bus in the same cycle.
- R3: With latch-enable high and the bus clock held at a steady level, the output keeps the stored value whatever the input bus does.
- R4: With latch-enable high, the input bus present at the first system clock edge after the bus clock rises is stored, and it appears on the output right after that edge.
- R5: With output enable high, every output bit is high impedance.
- R6: While the output is high impedance, storage still captures (register mode) and tracks (transparent mode), and the stored value appears once output enable returns low.
- R7: When latch-enable goes from low to high, the output shows the input bus sampled at the last system clock edge at which latch-enable was low.
- R8: A rising bus clock while latch-enable is low causes nothing beyond transparency. The value held after a later switch to register mode is the last value passed, not the value at that edge.
- R9: A synchronous active-low reset clears the stored value to all zeros.
- R10: A falling bus clock never captures data.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | Input data bus |
| lat_en | input | 1 | Mode select: 0 transparent, 1 register |
| bus_clk | input | 1 | Bus clock level, captured on its rising edge in register mode |
| out_en_n | input | 1 | Active-low output enable |
| y_out | output | WIDTH | Output data bus, high impedance when disabled |

## Verification
A stored bit with the wrong value stays hidden while the block is transparent. It shows on the output in the same cycle that latch-enable goes high, so each mode switch is followed at once by a check of the held value. A missed or false capture shows one system cycle after the bus clock level changes, and it persists until the next rising bus edge. The sweeps are therefore built so that every captured pattern differs from both its predecessor and the input that follows it. Output enable faults show at once as driven bits on a bus that should be floating.

// File: rtl/bld_pkg.sv
// Package: shared types for the latch/register bus driver.
// Assumes nothing beyond being compiled before the modules that import it.
package bld_pkg;

    // Per-cycle action that every storage bit performs at the next system edge.
    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,  // transparent: storage tracks the input
        MODE_HOLD    = 2'd1,  // register, no edge: storage keeps its value
        MODE_CAPTURE = 2'd2   // register, rising bus clock: storage loads input
    } bld_mode_e;

    // Decode latch-enable and the edge strobe into a storage action.
    function automatic bld_mode_e decode_mode(input logic lat_en, input logic rise);
        if (!lat_en)   return MODE_PASS;
        else if (rise) return MODE_CAPTURE;
        else           return MODE_HOLD;
    endfunction

endpackage

// File: rtl/bld_edge_detect.sv
// Module: rising-edge detector for the sampled bus clock level.
// Assumes bus_clk is synchronous to clk. The previous level is tracked even
// during reset, so a bus clock that is high when reset releases is not taken
// as an edge.
module bld_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    output logic rise
);

    logic prev_lvl;

    // Remember the bus clock level seen at the last system edge.
    always_ff @(posedge clk) begin
        prev_lvl <= bus_clk;
    end

    // An edge is a high level now after a low level at the last system edge.
    always_comb begin
        rise = bus_clk & ~prev_lvl;
    end

    // R4: an edge strobe lasts a single system cycle.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R10: a falling bus clock never raises the strobe.
    a_r10_no_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_clk) |-> !rise);

endmodule

// File: rtl/bld_store_cell.sv
// Module: one storage bit of the driver. It tracks, holds or captures as the
// shared mode says, and it offers the bit to the output (the input itself
// when transparent, the stored bit otherwise).
// Assumes mode is decoded once for the whole bus, so all bits act together.
module bld_store_cell
    import bld_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bld_mode_e mode,
    input  logic      d_in,
    output logic      d_out
);

    logic q;

    // Update the stored bit: cleared in reset, loaded in pass/capture, else kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (mode)
                MODE_PASS, MODE_CAPTURE: q <= d_in;
                default:                 q <= q;
            endcase
        end
    end

    // Select the transparent input or the stored bit for the output stage.
    always_comb begin
        d_out = (mode == MODE_PASS) ? d_in : q;
    end

    // R3: with no edge in register mode the stored bit does not move.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q));

    // R4: a capture cycle stores the input seen at that edge.
    a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPTURE) |=> (q == $past(d_in)));

    // R7: in transparent mode storage follows the input edge by edge.
    a_r7_track_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PASS) |=> (q == $past(d_in)));

    // R9: a reset cycle leaves the stored bit cleared.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0));

endmodule

// File: rtl/bld_out_stage.sv
// Module: tri-state output stage. It drives the bus when the active-low
// enable is low and releases every bit otherwise.
// Assumes the outer net may carry other drivers or pulls while released.
module bld_out_stage #(
    parameter int WIDTH = 20
) (
    input  logic             out_en_n,
    input  logic [WIDTH-1:0] d,
    output wire  [WIDTH-1:0] y
);

    localparam logic [WIDTH-1:0] ALL_Z = {WIDTH{1'bz}};

    // Drive the data or float the whole bus.
    assign y = out_en_n ? ALL_Z : d;

endmodule

// File: rtl/bus_latch_driver.sv
// Module: top of the latch/register bus driver. One shared mode decode feeds
// WIDTH identical storage bits, which feed a tri-state output stage.
// Assumes a_in, lat_en and bus_clk are synchronous to clk. Storage is
// independent of out_en_n.
module bus_latch_driver
    import bld_pkg::*;
#(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             lat_en,
    input  logic             bus_clk,
    input  logic             out_en_n,
    output wire  [WIDTH-1:0] y_out
);

    localparam int LAST_BIT = WIDTH - 1;

    logic             rise;
    bld_mode_e        mode;
    logic [LAST_BIT:0] cell_out;

    // Find the rising bus clock edge.
    bld_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_clk (bus_clk),
        .rise    (rise)
    );

    // Pick the storage action shared by all bits this cycle.
    always_comb begin
        mode = decode_mode(lat_en, rise);
    end

    // One identical storage bit per bus bit.
    for (genvar i = 0; i <= LAST_BIT; i++) begin : g_bit
        bld_store_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .d_in  (a_in[i]),
            .d_out (cell_out[i])
        );
    end

    // Drive or float the output bus.
    bld_out_stage #(.WIDTH(WIDTH)) u_out (
        .out_en_n (out_en_n),
        .d        (cell_out),
        .y        (y_out)
    );

    // R2: in transparent mode the data offered to the output is the input bus.
    a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_en |-> (cell_out == a_in));

endmodule

// File: tb/sim_bus_latch_driver.sv
`timescale 1ns/1ps
// Bench: sweeps all patterns of a narrow build through each mode. A pull-up
// on the output net makes a released bus read as all ones.
module sim_bus_latch_driver;

    localparam int W = 8;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic         le = 1'b0;
    logic         bclk = 1'b0;
    logic         oe_n = 1'b0;
    wire  [W-1:0] y_w;

    int errors = 0;
    int checks = 0;

    for (genvar i = 0; i < W; i++) begin : g_pu
        pullup (y_w[i]);
    end

    bus_latch_driver #(.WIDTH(W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (a),
        .lat_en   (le),
        .bus_clk  (bclk),
        .out_en_n (oe_n),
        .y_out    (y_w)
    );

    always #2 clk = ~clk;

    // Wait for a system edge, then step clear of it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Let combinational paths settle, then compare the output.
    task automatic chk(input string req, input logic [W-1:0] exp);
        #0.5;
        checks++;
        if (y_w !== exp) begin
            errors++;
            $display("FAIL %s: y=%h expected %h at %0t", req, y_w, exp, $time);
        end
    endtask

    // Load a value in register mode via a full bus clock pulse.
    task automatic capture(input logic [W-1:0] v);
        bclk = 1'b0;
        tick();
        a = v;
        bclk = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: y=%h expected completion", y_w);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset clears storage; shown in register mode.
        le = 1'b1;
        a = 8'hA5;
        tick(); tick(); tick();
        chk("R9", 8'h00);
        rst_n = 1'b1;
        a = 8'h5A;
        tick();
        chk("R9", 8'h00);

        // R2: transparent sweep over every pattern.
        le = 1'b0;
        for (int v = 0; v < 256; v++) begin
            a = W'(v);
            chk("R2", W'(v));
            tick();
        end

        // R7: switching to register mode holds the last passed value.
        a = 8'h3C;
        tick();
        le = 1'b1;
        a = 8'hC3;
        chk("R7", 8'h3C);

        // R3: with the bus clock steady low, input changes are ignored.
        for (int v = 0; v < 16; v++) begin
            a = W'(v * 17 + 1);
            tick();
            chk("R3", 8'h3C);
        end

        // R4: capture sweep; old value visible until the edge, new value after.
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] prev;
            prev = y_w;
            bclk = 1'b0;
            a = ~W'(v);
            tick();
            chk("R10", prev);
            a = W'(v);
            bclk = 1'b1;
            chk("R4", prev);
            tick();
            a = ~W'(v);
            chk("R4", W'(v));
        end

        // R3: bus clock held high, inputs ignored.
        capture(8'h96);
        for (int v = 0; v < 8; v++) begin
            a = W'(v * 31);
            tick();
            chk("R3", 8'h96);
        end

        // R10: falling bus clock does not capture.
        a = 8'h11;
        bclk = 1'b0;
        tick();
        tick();
        chk("R10", 8'h96);

        // R1: walking one per bit, then its complement.
        for (int i = 0; i < W; i++) begin
            capture(W'(1) << i);
            a = '0;
            chk("R1", W'(1) << i);
            capture(~(W'(1) << i));
            a = '1;
            chk("R1", ~(W'(1) << i));
        end

        // R8: a bus clock edge while transparent has no extra effect.
        le = 1'b0;
        bclk = 1'b0;
        a = 8'h22;
        tick();
        bclk = 1'b1;
        a = 8'h44;
        chk("R8", 8'h44);
        tick();
        chk("R8", 8'h44);
        a = 8'h66;
        tick();
        le = 1'b1;
        a = 8'h99;
        chk("R8", 8'h66);
        tick();
        chk("R8", 8'h66);

        // R5: released bus reads as pulled up in both modes.
        oe_n = 1'b1;
        le = 1'b0;
        for (int v = 0; v < 255; v++) begin
            a = W'(v);
            chk("R5", ONES);
            tick();
        end
        le = 1'b1;
        chk("R5", ONES);

        // R6: capture behind a released bus, then enable.
        capture(8'h5C);
        bclk = 1'b0;
        a = 8'h00;
        tick();
        chk("R6", ONES);
        oe_n = 1'b0;
        chk("R6", 8'h5C);

        // R6: tracking behind a released bus, then register mode and enable.
        oe_n = 1'b1;
        le = 1'b0;
        a = 8'h71;
        tick();
        chk("R6", ONES);
        le = 1'b1;
        a = 8'h00;
        oe_n = 1'b0;
        chk("R6", 8'h71);

        // R9: synchronous reset in the middle of operation.
        rst_n = 1'b0;
        chk("R9", 8'h71);
        tick();
        chk("R9", 8'h00);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule